// File: doc/BRIEF.md
# Fault-Degrading Four-Way Cache Tag Controller

This block holds the tag directory of a four-way set-associative cache and decides hit or miss for each lookup. Every way checks itself while it compares. A stored parity bit covers each tag. Each way has two independent comparators. A cross-way check catches more than one way matching the same address.

When any of these checks fails, the offending way is switched off for good. Lookups and line fills then continue on the remaining ways, so the cache loses associativity instead of stopping. The parity check and the comparator cross-check sit beside the main compare, not in series with it. Only the multihit resolution lies on the address-to-hit path.

A fill port writes tags into a victim way. The victim is picked round-robin among the enabled ways, with one pointer per set. Two test inputs let the bench and manufacturing test reach the parity and comparator faults from the ports. One stores an inverted parity bit on a fill. The other makes a chosen way's second comparator disagree.

Top module: `cache_tag_ctrl`

## Requirements
- R1: After reset, valid_o, hit_o and all error flags are 0. way_dis_o is 0, fault_code_o is 0 and all_failed_o is 0. Every stored entry is invalid.
- R2: An address is laid out as {tag[19:0], index[5:0]}, and the index selects one of 64 sets. A lookup strobed with req_i in one cycle gives valid_o=1 and its result on the next cycle. hit_way_o names the way whose tag matched. A cycle without req_i gives valid_o=0 and hit_o=0 on the next cycle.
- R3: A fill stores even parity over the tag, so the stored bit equals the XOR of the tag bits. With fill_par_flip_i=1 the inverted bit is stored. A lookup checks the parity of the valid entry in every enabled way of the indexed set. A mismatch raises par_err_o and disables that way.
- R4: Each way compares with two independent comparators. cmp_flip_i[w] inverts the second comparator of way w during a lookup. If the two comparators of a valid entry in an enabled way disagree, cmp_err_o is raised and that way is disabled.
- R5: If more than one fault-free enabled way matches, multi_err_o is raised. The lookup returns a miss, and every matching way is disabled.
- R6: The disable mask only gains bits and is cleared only by reset. A disabled way never produces a hit.
- R7: A fill writes the first enabled way found by scanning upward from the set's pointer, wrapping from way 3 to way 0. The pointer then moves to the way after the one written. A fill while all ways are disabled writes nothing.
- R8: When all four ways are disabled, all_failed_o is 1 and every lookup returns a miss.
- R9: fault_code_o[2w+1:2w] records why way w was disabled: 0 none, 1 parity, 2 comparator, 3 multihit. Parity takes priority over comparator, and comparator over multihit. The code is written once, when the way is disabled.
- R10: A way that faults during a lookup contributes no hit. A single fault-free matching way in the same set still hits in that lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Lookup strobe |
| addr_i | input | 26 | Lookup address {tag, index} |
| cmp_flip_i | input | 4 | Per-way inversion of the second comparator (test) |
| fill_i | input | 1 | Fill strobe |
| fill_addr_i | input | 26 | Fill address {tag, index} |
| fill_par_flip_i | input | 1 | Store inverted parity on this fill (test) |
| valid_o | output | 1 | Lookup result valid |
| hit_o | output | 1 | Lookup hit |
| hit_way_o | output | 2 | Way that hit |
| par_err_o | output | 1 | Parity fault seen in the last lookup |
| cmp_err_o | output | 1 | Comparator disagreement seen in the last lookup |
| multi_err_o | output | 1 | More than one way matched in the last lookup |
| way_dis_o | output | 4 | Disable mask, one bit per way |
| all_failed_o | output | 1 | All ways disabled |
| fault_code_o | output | 8 | Two-bit disable cause per way |

## Verification
The hardest situation to reach is a multihit. The fill path never writes one tag twice on purpose, and by then the cache has already lost ways to other faults. The bench reaches it in stages. It first disables way 0 with a fill carrying inverted parity. It then disables way 2 by flipping that way's second comparator during a lookup that still hits in way 3. Finally, it fills the same tag twice into one set, so the round-robin pointer must skip both dead ways and place the copies in ways 1 and 3. The bench then checks the multihit miss, the full disable mask, the all-failed flag and the accumulated cause codes.

// File: rtl/cache_tag_pkg.sv
package cache_tag_pkg;
  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_PAR   = 2'd1,
    FLT_CMP   = 2'd2,
    FLT_MULTI = 2'd3
  } flt_e;
endpackage

// File: rtl/cache_tag_way.sv
module cache_tag_way #(
  parameter int TAG_W = 20,
  parameter int IDX_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  input  logic             wr_par_flip_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  input  logic [TAG_W-1:0] rd_tag_i,
  input  logic             cmp_flip_i,
  output logic             hit_o,
  output logic             par_err_o,
  output logic             cmp_err_o
);
  localparam int SETS = 1 << IDX_W;

  logic [SETS-1:0]  vld_q;
  logic [TAG_W-1:0] tag_q [SETS];
  logic             par_q [SETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= '0;
    else if (we_i) vld_q[wr_idx_i] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      tag_q[wr_idx_i] <= wr_tag_i;
      par_q[wr_idx_i] <= (^wr_tag_i) ^ wr_par_flip_i;
    end
  end

  logic             rd_vld, rd_par, match_a, match_b;
  logic [TAG_W-1:0] rd_tag;

  assign rd_vld = vld_q[rd_idx_i];
  assign rd_tag = tag_q[rd_idx_i];
  assign rd_par = par_q[rd_idx_i];

  // two structurally different comparators
  assign match_a = (rd_tag == rd_tag_i);
  assign match_b = ~(|(rd_tag ^ rd_tag_i)) ^ cmp_flip_i;

  assign hit_o     = rd_vld & match_a;
  assign par_err_o = rd_vld & ((^rd_tag) ^ rd_par);
  assign cmp_err_o = rd_vld & (match_a ^ match_b);

  // R3
  par_gen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !wr_par_flip_i) |=>
      ((^tag_q[$past(wr_idx_i)]) == par_q[$past(wr_idx_i)]));
endmodule

// File: rtl/cache_tag_resolve.sv
module cache_tag_resolve import cache_tag_pkg::*; #(
  parameter int WAYS = 4
) (
  input  logic [WAYS-1:0]                 en_i,
  input  logic [WAYS-1:0]                 hit_i,
  input  logic [WAYS-1:0]                 par_i,
  input  logic [WAYS-1:0]                 cmp_i,
  output logic                            hit_o,
  output logic [$clog2(WAYS)-1:0]         hit_way_o,
  output logic                            par_o,
  output logic                            cmp_o,
  output logic                            multi_o,
  output logic [WAYS-1:0]                 kill_o,
  output logic [WAYS-1:0][1:0]            code_o
);
  localparam int WL = $clog2(WAYS);

  logic [WAYS-1:0] bad, raw;

  assign bad     = en_i & (par_i | cmp_i);
  assign raw     = en_i & hit_i & ~bad;
  assign multi_o = ($countones(raw) > 1);
  assign hit_o   = (raw != '0) && !multi_o;
  assign par_o   = |(en_i & par_i);
  assign cmp_o   = |(en_i & cmp_i);

  always_comb begin
    hit_way_o = '0;
    for (int w = 0; w < WAYS; w++)
      if (raw[w]) hit_way_o = WL'(w);
  end

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      kill_o[w] = bad[w] | (multi_o & raw[w]);
      if (en_i[w] && par_i[w])      code_o[w] = FLT_PAR;
      else if (en_i[w] && cmp_i[w]) code_o[w] = FLT_CMP;
      else if (multi_o && raw[w])   code_o[w] = FLT_MULTI;
      else                          code_o[w] = FLT_NONE;
    end
  end

  // R10
  always_comb begin
    hit_clean_chk: assert (!hit_o || ((kill_o & raw) == '0));
  end
endmodule

// File: rtl/cache_tag_victim.sv
module cache_tag_victim #(
  parameter int WAYS  = 4,
  parameter int IDX_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fill_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [WAYS-1:0]  en_i,
  output logic [WAYS-1:0]  we_o
);
  localparam int SETS = 1 << IDX_W;
  localparam int WL   = $clog2(WAYS);

  logic [WL-1:0] ptr_q [SETS];
  logic [WL-1:0] sel, cand;
  logic          found;

  always_comb begin
    found = 1'b0;
    sel   = '0;
    cand  = '0;
    for (int k = 0; k < WAYS; k++) begin
      cand = ptr_q[idx_i] + WL'(k);
      if (!found && en_i[cand]) begin
        found = 1'b1;
        sel   = cand;
      end
    end
  end

  always_comb begin
    we_o = '0;
    if (fill_i && found) we_o[sel] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
    end else if (fill_i && found) begin
      ptr_q[idx_i] <= sel + WL'(1);
    end
  end

  // R7
  fill_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i && (en_i != '0)) |-> ($onehot(we_o) && ((we_o & ~en_i) == '0)));
  // R7
  fill_dead_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i == '0) |-> (we_o == '0));
endmodule

// File: rtl/cache_tag_ctrl.sv
module cache_tag_ctrl import cache_tag_pkg::*; #(
  parameter int TAG_W = 20,
  parameter int IDX_W = 6,
  parameter int WAYS  = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_i,
  input  logic [TAG_W+IDX_W-1:0]   addr_i,
  input  logic [WAYS-1:0]          cmp_flip_i,
  input  logic                     fill_i,
  input  logic [TAG_W+IDX_W-1:0]   fill_addr_i,
  input  logic                     fill_par_flip_i,
  output logic                     valid_o,
  output logic                     hit_o,
  output logic [$clog2(WAYS)-1:0]  hit_way_o,
  output logic                     par_err_o,
  output logic                     cmp_err_o,
  output logic                     multi_err_o,
  output logic [WAYS-1:0]          way_dis_o,
  output logic                     all_failed_o,
  output logic [2*WAYS-1:0]        fault_code_o
);
  localparam int WL = $clog2(WAYS);

  logic [IDX_W-1:0] rd_idx, wr_idx;
  logic [TAG_W-1:0] rd_tag, wr_tag;
  assign {rd_tag, rd_idx} = addr_i;
  assign {wr_tag, wr_idx} = fill_addr_i;

  logic [WAYS-1:0]      dis_q, en, fill_we, w_hit, w_par, w_cmp, kill;
  logic [WAYS-1:0][1:0] kill_code, code_q;
  logic                 r_hit, r_par, r_cmp, r_multi;
  logic [WL-1:0]        r_way;

  assign en = ~dis_q;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    cache_tag_way #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_way (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .we_i          (fill_we[w]),
      .wr_idx_i      (wr_idx),
      .wr_tag_i      (wr_tag),
      .wr_par_flip_i (fill_par_flip_i),
      .rd_idx_i      (rd_idx),
      .rd_tag_i      (rd_tag),
      .cmp_flip_i    (cmp_flip_i[w] & req_i),
      .hit_o         (w_hit[w]),
      .par_err_o     (w_par[w]),
      .cmp_err_o     (w_cmp[w])
    );
  end

  cache_tag_resolve #(.WAYS(WAYS)) u_resolve (
    .en_i      (en),
    .hit_i     (w_hit),
    .par_i     (w_par),
    .cmp_i     (w_cmp),
    .hit_o     (r_hit),
    .hit_way_o (r_way),
    .par_o     (r_par),
    .cmp_o     (r_cmp),
    .multi_o   (r_multi),
    .kill_o    (kill),
    .code_o    (kill_code)
  );

  cache_tag_victim #(.WAYS(WAYS), .IDX_W(IDX_W)) u_victim (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fill_i (fill_i),
    .idx_i  (wr_idx),
    .en_i   (en),
    .we_o   (fill_we)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      hit_o       <= 1'b0;
      hit_way_o   <= '0;
      par_err_o   <= 1'b0;
      cmp_err_o   <= 1'b0;
      multi_err_o <= 1'b0;
      dis_q       <= '0;
      code_q      <= '0;
    end else begin
      valid_o     <= req_i;
      hit_o       <= req_i & r_hit;
      hit_way_o   <= req_i ? r_way : '0;
      par_err_o   <= req_i & r_par;
      cmp_err_o   <= req_i & r_cmp;
      multi_err_o <= req_i & r_multi;
      if (req_i) begin
        for (int w = 0; w < WAYS; w++)
          if (kill[w]) begin
            dis_q[w]  <= 1'b1;
            code_q[w] <= kill_code[w];
          end
      end
    end
  end

  assign way_dis_o    = dis_q;
  assign all_failed_o = &dis_q;
  assign fault_code_o = code_q;

  // R6
  dis_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((way_dis_o & $past(way_dis_o)) == $past(way_dis_o)));
  // R6
  hit_enabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> !way_dis_o[hit_way_o]);
  // R5
  multi_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    multi_err_o |-> !hit_o);
  // R8
  dead_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    all_failed_o |-> !hit_o);
  // R2
  hit_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> valid_o);
  // R9
  code_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(way_dis_o[0]) |-> (fault_code_o[1:0] != 2'd0));
endmodule

// File: tb/tb_cache_tag_ctrl.sv
module tb_cache_tag_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [25:0] addr = '0;
  logic [3:0]  cflip = '0;
  logic        fill = 1'b0;
  logic [25:0] faddr = '0;
  logic        pflip = 1'b0;
  logic        valid, hit, perr, cerr, merr, allf;
  logic [1:0]  hway;
  logic [3:0]  dis;
  logic [7:0]  code;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cache_tag_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .addr_i(addr), .cmp_flip_i(cflip),
    .fill_i(fill), .fill_addr_i(faddr), .fill_par_flip_i(pflip),
    .valid_o(valid), .hit_o(hit), .hit_way_o(hway), .par_err_o(perr),
    .cmp_err_o(cerr), .multi_err_o(merr), .way_dis_o(dis),
    .all_failed_o(allf), .fault_code_o(code)
  );

  function automatic logic [19:0] tg(int s, int w);
    return {4'h9, 2'(w), 8'(s), 6'h15};
  endfunction

  task automatic chk(string req_tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req_tag, act, exp);
    end
  endtask

  task automatic do_fill(logic [19:0] t, int s, logic flip);
    @(negedge clk);
    fill = 1'b1; faddr = {t, 6'(s)}; pflip = flip;
    @(negedge clk);
    fill = 1'b0; pflip = 1'b0;
  endtask

  task automatic lookup(logic [19:0] t, int s, logic [3:0] fl);
    @(negedge clk);
    req = 1'b1; addr = {t, 6'(s)}; cflip = fl;
    @(negedge clk);
    req = 1'b0; cflip = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk("R1 valid", valid, 0); chk("R1 hit", hit, 0);
    chk("R1 dis", dis, 0); chk("R1 code", code, 0); chk("R1 allf", allf, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: empty directory misses everywhere
    for (int s = 0; s < 64; s++) begin
      lookup(tg(s, 0), s, '0);
      chk("R1 empty miss", hit, 0);
      chk("R2 valid", valid, 1);
    end
    @(negedge clk);
    chk("R2 idle valid", valid, 0);

    // R7: four fills per set land in ways 0..3
    for (int s = 0; s < 64; s++)
      for (int w = 0; w < 4; w++) do_fill(tg(s, w), s, 1'b0);
    for (int s = 0; s < 64; s++)
      for (int w = 0; w < 4; w++) begin
        lookup(tg(s, w), s, '0);
        chk("R2 hit", hit, 1);
        chk("R7 way", hway, w);
        chk("R3 no perr", perr, 0);
      end
    lookup({4'h3, 16'h0}, 9, '0);
    chk("R2 absent miss", hit, 0);

    // R7: pointer wraps to way 0
    do_fill(20'hABCDE, 0, 1'b0);
    lookup(20'hABCDE, 0, '0);
    chk("R7 wrap hit", hit, 1); chk("R7 wrap way", hway, 0);
    lookup(tg(0, 0), 0, '0);
    chk("R7 replaced miss", hit, 0);

    // R3: inverted parity into set 1 way 0
    do_fill(20'h12345, 1, 1'b1);
    lookup(20'h12345, 1, '0);
    chk("R3 perr", perr, 1); chk("R3 miss", hit, 0);
    chk("R3 dis", dis, 4'b0001); chk("R9 code par", code, 8'h01);
    lookup(tg(1, 1), 1, '0);
    chk("R10 survivor hit", hit, 1); chk("R10 survivor way", hway, 1);
    lookup(tg(5, 0), 5, '0);
    chk("R6 disabled no hit", hit, 0);

    // R7: fill skips disabled way 0
    do_fill(20'h0F0F0, 2, 1'b0);
    lookup(20'h0F0F0, 2, '0);
    chk("R7 skip hit", hit, 1); chk("R7 skip way", hway, 1);
    lookup(tg(2, 1), 2, '0);
    chk("R7 skip replaced", hit, 0);

    // R4/R10: comparator fault on way 2 while way 3 hits
    lookup(tg(3, 3), 3, 4'b0100);
    chk("R4 cerr", cerr, 1); chk("R10 hit", hit, 1); chk("R10 way", hway, 3);
    chk("R4 dis", dis, 4'b0101); chk("R9 code cmp", code, 8'h21);

    // R5: duplicate tag into ways 1 and 3
    do_fill(20'h55AA5, 4, 1'b0);
    do_fill(20'h55AA5, 4, 1'b0);
    lookup(20'h55AA5, 4, '0);
    chk("R5 merr", merr, 1); chk("R5 miss", hit, 0);
    chk("R5 dis", dis, 4'b1111);
    chk("R8 allf", allf, 1); chk("R9 code all", code, 8'hED);

    // R8: dead cache
    lookup(tg(6, 1), 6, '0);
    chk("R8 miss", hit, 0); chk("R8 valid", valid, 1);
    do_fill(20'h77777, 6, 1'b0);
    lookup(20'h77777, 6, '0);
    chk("R8 fill ignored", hit, 0);
    chk("R6 mask kept", dis, 4'b1111);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule